// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block takes a request to process an application vector of arbitrary length and breaks it into pieces that fit the vector register capacity (`MVL` elements, 64 by default). For each piece it offers downstream vector units an element count and the index of the first element of that piece. It then waits for those units to report completion before it offers the next piece.

The short leftover piece is issued first. When the total length is not a multiple of `MVL`, the first piece carries `len mod MVL` elements and every later piece carries exactly `MVL`. For example, 264 elements become 8, 64, 64, 64, 64. When the total is a multiple of `MVL`, every piece is full and no empty piece is sent. A zero-length request produces no pieces and completes on its own.

The job request and the piece outputs are valid/ready streams. A stream transfers only in a cycle where both valid and ready are high. Once `chunk_valid` is raised, it stays high and `chunk_vl` and `chunk_offset` stay unchanged until `chunk_ready` is seen. `job_ready` is high only while the block is idle, so a new job waits until the previous one has finished. `chunk_done` and `job_done` are plain one-cycle pulses.

Top module: `stripmine_seq`

## Requirements
- R1: After reset, `job_ready` is 1, and `chunk_valid` and `job_done` are 0.
- R2: When the job length is not a multiple of MVL (64), the first piece has `chunk_vl` equal to length mod 64.
- R3: Every piece after the first has `chunk_vl` of exactly 64. When the length is a multiple of 64, every piece is 64, and `chunk_vl` is never 0 while `chunk_valid` is high.
- R4: `chunk_offset` of each piece equals the sum of the lengths of all earlier pieces of the same job, so the first offset is 0.
- R5: While `chunk_valid` is high and `chunk_ready` is low, `chunk_valid` stays high and `chunk_vl` and `chunk_offset` stay unchanged in the next cycle.
- R6: After a piece is accepted, `chunk_valid` stays low until `chunk_done` is seen. A `chunk_done` pulse that arrives while a piece is still being offered is ignored and does not advance the sequence.
- R7: A job of length 0 issues no piece. `job_done` is high in the first cycle after the job is accepted.
- R8: `job_done` is a one-cycle pulse in the first cycle after the `chunk_done` of the last piece. `job_ready` returns to 1 in the cycle after that.
- R9: While a job is in progress, `job_ready` is 0 and `job_valid`/`job_len` are ignored. The pieces of the running job do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job request valid |
| job_ready | output | 1 | Sequencer idle, job can be taken |
| job_len | input | 16 | Total element count of the job |
| chunk_valid | output | 1 | Piece descriptor valid |
| chunk_ready | input | 1 | Downstream takes the piece |
| chunk_vl | output | 7 | Element count of the piece (1 to 64) |
| chunk_offset | output | 16 | Index of the first element of the piece |
| chunk_done | input | 1 | Pulse: downstream finished the accepted piece |
| job_done | output | 1 | Pulse: every piece of the job has finished |

## Verification
The lengths tried are 264, 5, 128, 64 and 0. The 264 case has a remainder and several full pieces. The value 5 fits in one short piece. The value 128 is an exact multiple, which would expose an empty leading piece. The value 64 is a single full piece, which exposes a wrong choice between 0 and 64 for a zero remainder. The zero-length job separates an immediate completion from a spurious issue. Further runs add back-pressure on `chunk_ready`, slow `chunk_done` replies, early `chunk_done` pulses during the offer, and `job_valid` raised mid-job. These runs show whether descriptors hold steady and whether stray inputs leave the offset sequence intact.

// File: rtl/stripmine_pkg.sv
package stripmine_pkg;
  typedef enum logic [1:0] {
    SM_IDLE   = 2'd0,
    SM_ISSUE  = 2'd1,
    SM_WAIT   = 2'd2,
    SM_FINISH = 2'd3
  } sm_state_e;
endpackage

// File: rtl/stripmine_split.sv
// Derives the length of the piece to issue from the elements still left.
// Because the leftover piece goes first, what remains after it is always a
// multiple of MVL, so (remaining mod MVL) is only nonzero on the first piece.
module stripmine_split #(
  parameter int MVL   = 64,
  parameter int LEN_W = 16,
  parameter int VL_W  = 7
) (
  input  logic [LEN_W-1:0] remaining,
  output logic [VL_W-1:0]  vl,
  output logic             last
);
  localparam int  MOD_W  = (MVL > 1) ? $clog2(MVL) : 1;
  localparam bit  IS_POW2 = (MVL > 1) && ((MVL & (MVL - 1)) == 0);

  logic [VL_W-1:0] rem_part;

  generate
    if (IS_POW2) begin : g_pow2
      assign rem_part = VL_W'(remaining[MOD_W-1:0]);
    end else begin : g_generic
      logic [LEN_W-1:0] rem_full;
      assign rem_full = remaining % LEN_W'(MVL);
      assign rem_part = VL_W'(rem_full);
    end
  endgenerate

  always_comb begin
    vl   = (rem_part == '0) ? VL_W'(MVL) : rem_part;
    last = (remaining == LEN_W'(vl));
  end
endmodule

// File: rtl/stripmine_track.sv
// Holds the count of elements not yet issued and the running start offset.
module stripmine_track #(
  parameter int LEN_W = 16,
  parameter int VL_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             advance,
  input  logic [VL_W-1:0]  step,
  output logic [LEN_W-1:0] remaining,
  output logic [LEN_W-1:0] offset
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      offset    <= '0;
    end else if (load) begin
      remaining <= load_len;
      offset    <= '0;
    end else if (advance) begin
      remaining <= remaining - LEN_W'(step);
      offset    <= offset + LEN_W'(step);
    end
  end
endmodule

// File: rtl/stripmine_ctrl.sv
// Sequencing state machine: idle, offer piece, wait for completion, finish.
module stripmine_ctrl
  import stripmine_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic job_valid,
  input  logic len_zero,
  input  logic chunk_ready,
  input  logic chunk_done,
  input  logic last,
  output logic job_ready,
  output logic chunk_valid,
  output logic job_done,
  output logic load,
  output logic advance
);
  sm_state_e state_q, state_d;

  always_comb begin
    job_ready   = (state_q == SM_IDLE);
    chunk_valid = (state_q == SM_ISSUE);
    job_done    = (state_q == SM_FINISH);
    load        = job_ready && job_valid;
    advance     = (state_q == SM_WAIT) && chunk_done;
    state_d     = state_q;
    unique case (state_q)
      SM_IDLE:   if (job_valid) state_d = len_zero ? SM_FINISH : SM_ISSUE;
      SM_ISSUE:  if (chunk_ready) state_d = SM_WAIT;
      SM_WAIT:   if (chunk_done) state_d = last ? SM_FINISH : SM_ISSUE;
      SM_FINISH: state_d = SM_IDLE;
      default:   state_d = SM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SM_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/stripmine_seq.sv
module stripmine_seq #(
  parameter int MVL   = 64,
  parameter int LEN_W = 16,
  parameter int VL_W  = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             job_valid,
  output logic             job_ready,
  input  logic [LEN_W-1:0] job_len,
  output logic             chunk_valid,
  input  logic             chunk_ready,
  output logic [VL_W-1:0]  chunk_vl,
  output logic [LEN_W-1:0] chunk_offset,
  input  logic             chunk_done,
  output logic             job_done
);
  logic             load, advance, last;
  logic [LEN_W-1:0] remaining;

  stripmine_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .job_valid  (job_valid),
    .len_zero   (job_len == '0),
    .chunk_ready(chunk_ready),
    .chunk_done (chunk_done),
    .last       (last),
    .job_ready  (job_ready),
    .chunk_valid(chunk_valid),
    .job_done   (job_done),
    .load       (load),
    .advance    (advance)
  );

  stripmine_split #(.MVL(MVL), .LEN_W(LEN_W), .VL_W(VL_W)) split_i (
    .remaining(remaining),
    .vl       (chunk_vl),
    .last     (last)
  );

  stripmine_track #(.LEN_W(LEN_W), .VL_W(VL_W)) track_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_len (job_len),
    .advance  (advance),
    .step     (chunk_vl),
    .remaining(remaining),
    .offset   (chunk_offset)
  );
endmodule

// File: rtl/stripmine_seq_chk.sv
module stripmine_seq_chk #(
  parameter int MVL   = 64,
  parameter int LEN_W = 16,
  parameter int VL_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             job_valid,
  input logic             job_ready,
  input logic [LEN_W-1:0] job_len,
  input logic             chunk_valid,
  input logic             chunk_ready,
  input logic [VL_W-1:0]  chunk_vl,
  input logic [LEN_W-1:0] chunk_offset,
  input logic             chunk_done,
  input logic             job_done
);
  localparam logic [LEN_W-1:0] MVL_L = LEN_W'(MVL);

  logic [LEN_W-1:0] n_q, sum_q;
  logic             first_q, inflight_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q <= '0; sum_q <= '0; first_q <= 1'b0; inflight_q <= 1'b0;
    end else begin
      if (job_valid && job_ready) begin
        n_q <= job_len; sum_q <= '0; first_q <= 1'b1;
      end else if (chunk_valid && chunk_ready) begin
        sum_q <= sum_q + LEN_W'(chunk_vl); first_q <= 1'b0;
      end
      if (chunk_valid && chunk_ready) inflight_q <= 1'b1;
      else if (chunk_done)            inflight_q <= 1'b0;
    end
  end

  AST_FIRST_REMAINDER: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && first_q && (n_q % MVL_L) != '0) |-> LEN_W'(chunk_vl) == (n_q % MVL_L)); // R2
  AST_LATER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !first_q) |-> LEN_W'(chunk_vl) == MVL_L); // R3
  AST_VL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (chunk_vl != '0 && LEN_W'(chunk_vl) <= MVL_L)); // R3
  AST_OFFSET_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> chunk_offset == sum_q); // R4
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready) |=> (chunk_valid && $stable(chunk_vl) && $stable(chunk_offset))); // R5
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q |-> !chunk_valid); // R6
  AST_DONE_COVERS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> (sum_q == n_q && !inflight_q)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> (!job_done && job_ready)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid || inflight_q) |-> !job_ready); // R9
endmodule

bind stripmine_seq stripmine_seq_chk #(.MVL(MVL), .LEN_W(LEN_W), .VL_W(VL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
  .job_len(job_len), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
  .chunk_vl(chunk_vl), .chunk_offset(chunk_offset), .chunk_done(chunk_done),
  .job_done(job_done)
);

// File: tb/stripmine_seq_tb_top.sv
`timescale 1ns/1ps
module stripmine_seq_tb_top;
  localparam int MVL = 64;
  localparam int LEN_W = 16;
  localparam int VL_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic job_valid = 1'b0, chunk_ready = 1'b0, chunk_done = 1'b0;
  logic [LEN_W-1:0] job_len = '0;
  logic job_ready, chunk_valid, job_done;
  logic [VL_W-1:0] chunk_vl;
  logic [LEN_W-1:0] chunk_offset;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  stripmine_seq #(.MVL(MVL), .LEN_W(LEN_W), .VL_W(VL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_len(job_len), .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_vl(chunk_vl), .chunk_offset(chunk_offset), .chunk_done(chunk_done),
    .job_done(job_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One job: bp = stall cycles before accepting each piece, dd = cycles
  // before the completion pulse, spur = stray done during stall,
  // noise = job_valid raised while waiting.
  task automatic run_job(input int n, input int bp, input int dd, input bit spur, input bit noise);
    int rem = n;
    int off = 0;
    int exp_vl;
    @(negedge clk);
    check(job_ready == 1'b1, "R8 job_ready idle", int'(job_ready), 1);
    job_valid = 1'b1; job_len = LEN_W'(n);
    @(negedge clk);
    job_valid = 1'b0; job_len = '0;
    if (n == 0) begin
      check(chunk_valid == 1'b0, "R7 no piece", int'(chunk_valid), 0);
      check(job_done == 1'b1, "R7 done pulse", int'(job_done), 1);
      @(negedge clk);
      check(job_done == 1'b0, "R8 done one cycle", int'(job_done), 0);
      return;
    end
    while (rem > 0) begin
      exp_vl = (rem % MVL != 0) ? rem % MVL : MVL;
      check(chunk_valid == 1'b1, "R6 piece offered", int'(chunk_valid), 1);
      check(job_ready == 1'b0, "R9 busy", int'(job_ready), 0);
      for (int i = 0; i < bp; i++) begin
        chunk_done = spur && (i == 0);
        @(negedge clk);
        chunk_done = 1'b0;
        check(chunk_valid == 1'b1, "R5 valid held", int'(chunk_valid), 1);
        check(int'(chunk_offset) == off, "R5 offset held", int'(chunk_offset), off);
      end
      if (off == 0) check(int'(chunk_vl) == exp_vl, "R2 first length", int'(chunk_vl), exp_vl);
      else          check(int'(chunk_vl) == MVL, "R3 full length", int'(chunk_vl), MVL);
      check(int'(chunk_offset) == off, "R4 offset", int'(chunk_offset), off);
      chunk_ready = 1'b1;
      @(negedge clk);
      chunk_ready = 1'b0;
      check(chunk_valid == 1'b0, "R6 wait after accept", int'(chunk_valid), 0);
      for (int i = 0; i < dd; i++) begin
        if (noise) begin job_valid = 1'b1; job_len = 16'd7; end
        @(negedge clk);
        check(chunk_valid == 1'b0, "R6 no issue before done", int'(chunk_valid), 0);
        check(job_ready == 1'b0, "R9 job_ready low", int'(job_ready), 0);
      end
      job_valid = 1'b0; job_len = '0;
      chunk_done = 1'b1;
      @(negedge clk);
      chunk_done = 1'b0;
      rem -= exp_vl; off += exp_vl;
      if (rem == 0) begin
        check(job_done == 1'b1, "R8 done after last", int'(job_done), 1);
        check(chunk_valid == 1'b0, "R3 no empty piece", int'(chunk_valid), 0);
        @(negedge clk);
        check(job_done == 1'b0, "R8 done one cycle", int'(job_done), 0);
        check(job_ready == 1'b1, "R8 ready again", int'(job_ready), 1);
      end else begin
        check(job_done == 1'b0, "R8 no early done", int'(job_done), 0);
      end
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(job_ready == 1'b1, "R1 job_ready", int'(job_ready), 1);
    check(chunk_valid == 1'b0, "R1 chunk_valid", int'(chunk_valid), 0);
    check(job_done == 1'b0, "R1 job_done", int'(job_done), 0);
  endtask

  initial begin
    #1_000_000;
    n_fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_job(264, 0, 0, 1'b0, 1'b0);  // R2 R3: 8 then four 64
    run_job(5,   0, 1, 1'b0, 1'b0);  // R2 single short piece
    run_job(128, 0, 0, 1'b0, 1'b0);  // R3 exact multiple
    run_job(64,  1, 0, 1'b0, 1'b0);  // R3 single full piece
    run_job(0,   0, 0, 1'b0, 1'b0);  // R7
    run_job(200, 3, 2, 1'b1, 1'b0);  // R5 R6 stall with stray done
    run_job(70,  0, 3, 1'b0, 1'b1);  // R9 job_valid mid-job
    run_job(1,   0, 0, 1'b0, 1'b0);  // R2 minimum length
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule